// File: doc/BRIEF.md
# Serial converter command sequencer

This block sits on the host side of a multichannel serial analog-to-digital converter and runs its I/O cycles. Each cycle drops chip select, drives a serial clock, shifts one command byte out on the data-in line (command code in bits 7..4, configuration nibble in bits 3..0) and, during the same clocks, shifts in the result of the conversion that the previous command started. The number of serial clocks in a cycle is 8, 12 or 16. The byte being sent decides it, so the sequencer works out the length of each frame from the request it is serving at that moment.

A user posts a request made of a command code, an output-length field, a bit-order flag and a format flag. The block reports each received result right-justified in 16 bits, reordered to MSB first and sign-extended when the bipolar format is in force. Each result carries the command code it belongs to, which is the code sent one frame earlier. Code 15 sends the nibble to the second configuration register. For such a frame the first register keeps its stored settings, and bit 0 of the nibble restores the defaults. After each frame the block holds chip select high until end-of-conversion has gone low and then high again, or until a timeout expires.

The control is a four-state machine:
- ST_IDLE leaves on an accepted request (IDLE to SCLK_LO).
- ST_SCLK_LO leaves after a half period (LO to HI, rising serial edge).
- ST_SCLK_HI leaves after a half period. It goes back to ST_SCLK_LO on a falling edge that is not the last one, or on to ST_CONV_WAIT on the last falling edge.
- ST_CONV_WAIT leaves when end-of-conversion is seen low and then high, or when the timeout expires (CONV_WAIT to IDLE).

Top module: `adc_cmd_seq`

## Requirements
- R1: After reset, adc_cs_n is 1, adc_sclk is 0, res_valid is 0 and req_ready is 1.
- R2: Within a frame, adc_sdi presents the byte {req_cmd, req_len, req_lsb_first, req_bipolar} MSB first, one bit per serial clock, stable at each rising edge; after the eighth bit it is 0.
- R3: For a command code other than 15, the frame has exactly 8 serial clocks when req_len is 01, 16 when it is 11, and 12 when it is 00 or 10.
- R4: A frame with code 15 uses the stored length, order and format of the last non-15 request (reset value: 16 clocks, MSB first, unipolar). If bit 0 of its nibble (req_bipolar) is 1, the stored settings return to that reset value for later frames.
- R5: adc_sclk is low whenever adc_cs_n is high, and adc_sdi changes only while adc_sclk is low. The period of adc_sclk is SCLK_DIV system clocks.
- R6: res_valid pulses for one cycle, on the clock on which adc_cs_n returns high, for every frame except the first one after reset.
- R7: res_data holds the L bits received in the frame, right-justified. With MSB-first order the first bit received is bit L-1. With LSB-first order the first bit received is bit 0.
- R8: When the frame's format flag is 1, bits 15..L of res_data copy bit L-1. Otherwise they are 0.
- R9: res_tag is the command code of the previous frame. res_sample is 1 when that code is below 14 and 0 for codes 14 and 15.
- R10: After a frame, no new frame starts until adc_eoc has been seen low and then high, or until TIMEOUT_CYC cycles have passed with no such event.
- R11: req_ready is 0 whenever adc_cs_n is low, and a request is taken only while req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_cmd | input | 4 | Command code (channel, test voltage, power-down, register select) |
| req_len | input | 2 | Output-length field |
| req_lsb_first | input | 1 | Bit-order flag |
| req_bipolar | input | 1 | Two's-complement format flag |
| res_valid | output | 1 | Result strobe |
| res_data | output | 16 | Right-justified result |
| res_tag | output | 4 | Command code the result belongs to |
| res_sample | output | 1 | Result is a converted sample |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_sdi | output | 1 | Command data to the converter |
| adc_sdo | input | 1 | Result data from the converter |
| adc_eoc | input | 1 | End-of-conversion status |

## Verification
A result falls due on the system clock edge on which chip select rises. The bench compares res_valid on every clock: it must be high only in the cycle just after that edge, and its data, tag and sample flag are checked there against a model that keeps the previous command and the stored configuration. The serial byte and the clock count are collected at the serial edges and compared once chip select has risen. The gap between frames is measured in clocks from the rise of chip select to the next fall. The bounds allow for the two-stage end-of-conversion synchroniser and the request handshake, and differ between the event case and the timeout case.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W = 16;
    localparam int LEN_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCLK_LO,
        ST_SCLK_HI,
        ST_CONV_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       lsb;
        logic       bip;
    } cfg1_t;

    localparam logic [3:0] CMD_PWRDN = 4'd14;
    localparam logic [3:0] CMD_CFG2  = 4'd15;
    localparam cfg1_t      CFG1_DEFAULT = '{len: 2'b11, lsb: 1'b0, bip: 1'b0};

    function automatic logic [LEN_W-1:0] frame_bits(input logic [1:0] len);
        unique case (len)
            2'b01:   return LEN_W'(8);
            2'b11:   return LEN_W'(16);
            default: return LEN_W'(12);
        endcase
    endfunction

endpackage

// File: rtl/adc_tick_cnt.sv
module adc_tick_cnt #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1) + 1;

    logic [W-1:0] cnt;

    assign hit = en && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= hit ? '0 : cnt + W'(1);
        end
    end
endmodule

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
    import adc_seq_pkg::*;
(
    input  logic [3:0]       cmd,
    input  cfg1_t            nibble,
    input  cfg1_t            stored,
    output cfg1_t            frame_cfg,
    output cfg1_t            next_cfg,
    output logic [LEN_W-1:0] frame_len
);
    logic to_cfg2;

    always_comb begin
        to_cfg2   = (cmd == CMD_CFG2);
        frame_cfg = to_cfg2 ? stored : nibble;
        if (!to_cfg2) begin
            next_cfg = nibble;
        end else if (nibble.bip) begin
            next_cfg = CFG1_DEFAULT;
        end else begin
            next_cfg = stored;
        end
        frame_len = frame_bits(frame_cfg.len);
    end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
    import adc_seq_pkg::*;
(
    input  logic [RES_W-1:0] shreg,
    input  logic [LEN_W-1:0] len,
    input  logic             lsb,
    input  logic             bip,
    output logic [RES_W-1:0] data
);
    logic [LEN_W-1:0] top;
    logic [LEN_W-1:0] j;
    logic             sign;

    always_comb begin
        top  = len - LEN_W'(1);
        sign = bip & (lsb ? shreg[0] : shreg[top[3:0]]);
        j    = '0;
        data = '0;
        for (int i = 0; i < RES_W; i++) begin
            j = top - LEN_W'(i);
            if (LEN_W'(i) < len) begin
                data[i] = lsb ? shreg[j[3:0]] : shreg[i];
            end else begin
                data[i] = sign;
            end
        end
    end
endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
    import adc_seq_pkg::*;
#(
    parameter int SCLK_DIV    = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [3:0]  req_cmd,
    input  logic [1:0]  req_len,
    input  logic        req_lsb_first,
    input  logic        req_bipolar,
    output logic        res_valid,
    output logic [15:0] res_data,
    output logic [3:0]  res_tag,
    output logic        res_sample,
    output logic        adc_cs_n,
    output logic        adc_sclk,
    output logic        adc_sdi,
    input  logic        adc_sdo,
    input  logic        adc_eoc
);
    localparam int HALF = SCLK_DIV / 2;

    seq_state_e state, state_nx;

    cfg1_t            cfg1_q;
    cfg1_t            frame_cfg_q;
    logic [LEN_W-1:0] frame_len_q;
    logic [7:0]       byte_q;
    logic [3:0]       cur_cmd;
    logic [3:0]       prev_cmd;
    logic             have_prev;
    logic [LEN_W-1:0] bit_idx;
    logic [LEN_W-1:0] nb;
    logic [RES_W-1:0] shreg;
    logic             seen_low;
    logic [1:0]       eoc_sync;
    logic             eoc_s;
    logic             half_hit;
    logic             to_hit;
    logic             last_bit;

    cfg1_t            dec_frame_cfg;
    cfg1_t            dec_next_cfg;
    logic [LEN_W-1:0] dec_len;
    logic [RES_W-1:0] fmt_data;

    assign eoc_s     = eoc_sync[1];
    assign req_ready = (state == ST_IDLE);
    assign last_bit  = (bit_idx == frame_len_q - LEN_W'(1));
    assign nb        = bit_idx + LEN_W'(1);

    adc_cmd_decode i_decode (
        .cmd       (req_cmd),
        .nibble    ('{len: req_len, lsb: req_lsb_first, bip: req_bipolar}),
        .stored    (cfg1_q),
        .frame_cfg (dec_frame_cfg),
        .next_cfg  (dec_next_cfg),
        .frame_len (dec_len)
    );

    adc_tick_cnt #(.LIMIT(HALF)) i_half (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state == ST_IDLE) || (state == ST_CONV_WAIT)),
        .en    ((state == ST_SCLK_LO) || (state == ST_SCLK_HI)),
        .hit   (half_hit)
    );

    adc_tick_cnt #(.LIMIT(TIMEOUT_CYC)) i_timeout (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_CONV_WAIT),
        .en    (state == ST_CONV_WAIT),
        .hit   (to_hit)
    );

    adc_result_fmt i_fmt (
        .shreg (shreg),
        .len   (frame_len_q),
        .lsb   (frame_cfg_q.lsb),
        .bip   (frame_cfg_q.bip),
        .data  (fmt_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (req_valid) state_nx = ST_SCLK_LO;
            ST_SCLK_LO:   if (half_hit) state_nx = ST_SCLK_HI;
            ST_SCLK_HI:   if (half_hit) state_nx = last_bit ? ST_CONV_WAIT : ST_SCLK_LO;
            ST_CONV_WAIT: if ((seen_low && eoc_s) || to_hit) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc_sync    <= 2'b11;
            adc_cs_n    <= 1'b1;
            adc_sclk    <= 1'b0;
            adc_sdi     <= 1'b0;
            cfg1_q      <= CFG1_DEFAULT;
            frame_cfg_q <= CFG1_DEFAULT;
            frame_len_q <= LEN_W'(16);
            byte_q      <= '0;
            cur_cmd     <= '0;
            prev_cmd    <= '0;
            have_prev   <= 1'b0;
            bit_idx     <= '0;
            shreg       <= '0;
            seen_low    <= 1'b0;
            res_valid   <= 1'b0;
            res_data    <= '0;
            res_tag     <= '0;
            res_sample  <= 1'b0;
        end else begin
            eoc_sync  <= {eoc_sync[0], adc_eoc};
            res_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    seen_low <= 1'b0;
                    if (req_valid) begin
                        adc_cs_n    <= 1'b0;
                        adc_sdi     <= req_cmd[3];
                        byte_q      <= {req_cmd, req_len, req_lsb_first, req_bipolar};
                        cur_cmd     <= req_cmd;
                        frame_cfg_q <= dec_frame_cfg;
                        frame_len_q <= dec_len;
                        cfg1_q      <= dec_next_cfg;
                        bit_idx     <= '0;
                        shreg       <= '0;
                    end
                end
                ST_SCLK_LO: begin
                    if (half_hit) begin
                        adc_sclk <= 1'b1;
                        shreg    <= {shreg[RES_W-2:0], adc_sdo};
                    end
                end
                ST_SCLK_HI: begin
                    if (half_hit) begin
                        adc_sclk <= 1'b0;
                        if (last_bit) begin
                            adc_cs_n   <= 1'b1;
                            adc_sdi    <= 1'b0;
                            res_valid  <= have_prev;
                            res_data   <= fmt_data;
                            res_tag    <= prev_cmd;
                            res_sample <= (prev_cmd < CMD_PWRDN);
                            prev_cmd   <= cur_cmd;
                            have_prev  <= 1'b1;
                        end else begin
                            bit_idx <= nb;
                            adc_sdi <= (nb < LEN_W'(8)) ? byte_q[3'd7 - nb[2:0]] : 1'b0;
                        end
                    end
                end
                ST_CONV_WAIT: begin
                    if (!eoc_s) seen_low <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/adc_cmd_seq_chk.sv
module adc_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       adc_cs_n,
    input logic       adc_sclk,
    input logic       adc_sdi,
    input logic       req_ready,
    input logic       res_valid
);
    logic [5:0] rise_cnt;
    logic       sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            sclk_q   <= 1'b0;
        end else begin
            sclk_q   <= adc_sclk;
            rise_cnt <= adc_cs_n ? 6'd0 : rise_cnt + {5'd0, (adc_sclk & ~sclk_q)};
        end
    end

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);

    p_sdi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk && $past(adc_sclk)) |-> $stable(adc_sdi));

    p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (rise_cnt == 6'd8 || rise_cnt == 6'd12 || rise_cnt == 6'd16));

    p_valid_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(adc_cs_n));

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_ready_deselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> adc_cs_n);
endmodule

bind adc_cmd_seq adc_cmd_seq_chk i_adc_cmd_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .adc_sdi   (adc_sdi),
    .req_ready (req_ready),
    .res_valid (res_valid)
);

// File: tb/test_adc_cmd_seq.sv
`timescale 1ns/1ps
module test_adc_cmd_seq;
    localparam int DIV = 4;
    localparam int TMO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [3:0] req_cmd = '0;
    logic [1:0] req_len = '0;
    logic req_lsb_first = 1'b0;
    logic req_bipolar = 1'b0;
    logic res_valid;
    logic [15:0] res_data;
    logic [3:0] res_tag;
    logic res_sample;
    logic adc_cs_n, adc_sclk, adc_sdi;
    logic adc_sdo = 1'b0;
    logic adc_eoc = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // model state
    logic [3:0] m_prev = '0;
    bit m_have = 0;
    logic [3:0] m_cfg = 4'b1100;
    // current frame stimulus and expectations
    logic [15:0] cur_pat = '0;
    int cur_L = 16;
    logic [7:0] cur_byte = '0;
    bit exp_valid = 0;
    logic [15:0] exp_data = '0;
    logic [3:0] exp_tag = '0;
    bit exp_sample = 0;
    bit eoc_stuck = 0;
    int eoc_dly = 8;
    int t_rise = 0;
    bit gap_on = 0;
    int gap_min = 0, gap_max = 0;
    // serial capture
    bit in_frame = 0;
    int kk = 0;
    int rcount = 0;
    logic [15:0] rx = '0;

    adc_cmd_seq #(.SCLK_DIV(DIV), .TIMEOUT_CYC(TMO)) i_adc_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_len(req_len), .req_lsb_first(req_lsb_first),
        .req_bipolar(req_bipolar), .res_valid(res_valid), .res_data(res_data),
        .res_tag(res_tag), .res_sample(res_sample), .adc_cs_n(adc_cs_n),
        .adc_sclk(adc_sclk), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo), .adc_eoc(adc_eoc)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] f);
        if (f == 2'b01) return 8;
        if (f == 2'b11) return 16;
        return 12;
    endfunction

    function automatic logic [15:0] model_fmt(input logic [15:0] pat, input int L, input bit lsb, input bit bip);
        logic [15:0] v = '0;
        for (int k = 0; k < L; k++) begin
            if (lsb) v[k] = pat[L-1-k];
            else v[L-1-k] = pat[L-1-k];
        end
        if (bip && v[L-1]) for (int i = L; i < 16; i++) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic sdo_bit(input int k);
        if (k < cur_L) return cur_pat[cur_L-1-k];
        return 1'b0;
    endfunction

    // converter side: serial data out, data-in capture, gap measurement
    always @(negedge adc_cs_n or negedge adc_sclk or posedge adc_sclk) begin
        if (adc_sclk) begin
            if (!adc_cs_n) begin
                rx = {rx[14:0], adc_sdi};
                rcount++;
            end
        end else if (!adc_cs_n && !in_frame) begin
            in_frame = 1;
            kk = 0;
            rcount = 0;
            rx = '0;
            adc_sdo = sdo_bit(0);
            if (gap_on) chk((cyc - t_rise) >= gap_min && (cyc - t_rise) <= gap_max,
                            "R10 frame gap", cyc - t_rise, gap_min);
        end else if (!adc_cs_n) begin
            kk++;
            adc_sdo = sdo_bit(kk);
        end else begin
            in_frame = 0;
        end
    end

    // end-of-conversion behaviour
    initial begin
        forever begin
            @(posedge adc_cs_n);
            t_rise = cyc;
            adc_eoc = 1'b0;
            if (!eoc_stuck) begin
                repeat (eoc_dly) @(negedge clk);
                adc_eoc = 1'b1;
            end
        end
    end

    // per-clock result comparison
    logic mon_cs = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!adc_cs_n && req_ready) chk(0, "R11 ready while selected", 1, 0);
            if (adc_cs_n && !mon_cs) begin
                chk(res_valid == exp_valid, "R6 valid at frame end", res_valid, exp_valid);
                if (exp_valid) begin
                    chk(res_data == exp_data, "R7/R8 data", res_data, exp_data);
                    chk(res_tag == exp_tag, "R9 tag", res_tag, exp_tag);
                    chk(res_sample == exp_sample, "R9 sample flag", res_sample, exp_sample);
                end
            end else if (res_valid) begin
                chk(0, "R6 stray valid", 1, 0);
            end
            mon_cs <= adc_cs_n;
        end
    end

    task automatic frame(input logic [3:0] cmd, input logic [1:0] len, input bit lsb, input bit bip,
                         input logic [15:0] pat, input bit stuck, input int dly, input string tag);
        logic [3:0] fcfg, ncfg;
        logic [15:0] exp_rx;
        if (cmd != 4'd15) begin
            fcfg = {len, lsb, bip};
            ncfg = {len, lsb, bip};
        end else begin
            fcfg = m_cfg;
            ncfg = bip ? 4'b1100 : m_cfg;
        end
        cur_L = len_of(fcfg[3:2]);
        cur_pat = pat;
        cur_byte = {cmd, len, lsb, bip};
        exp_valid = m_have;
        exp_data = model_fmt(pat, cur_L, fcfg[1], fcfg[0]);
        exp_tag = m_prev;
        exp_sample = (m_prev < 4'd14);
        eoc_stuck = stuck;
        eoc_dly = dly;
        while (!req_ready) @(negedge clk);
        req_cmd = cmd; req_len = len; req_lsb_first = lsb; req_bipolar = bip;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge adc_cs_n);
        @(negedge clk);
        #1;
        chk(rcount == cur_L, {tag, " serial clock count"}, rcount, cur_L);
        exp_rx = 16'({cur_byte, 8'h00} >> (16 - cur_L));
        chk(rx == exp_rx, "R2 command byte on data-in", rx, exp_rx);
        m_prev = cmd;
        m_have = 1;
        m_cfg = ncfg;
        gap_on = 1;
        gap_min = stuck ? TMO : dly;
        gap_max = stuck ? TMO + 4 : dly + 8;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1 cs_n after reset", adc_cs_n, 1);
        chk(adc_sclk == 1'b0, "R1 sclk after reset", adc_sclk, 0);
        chk(res_valid == 1'b0, "R1 valid after reset", res_valid, 0);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1 && adc_cs_n == 1'b1, "R1 idle after release", req_ready, 1);
        frame(4'd3,  2'b11, 0, 0, 16'hA5C3, 0, 8,  "R3 16-bit");
        frame(4'd5,  2'b01, 1, 0, 16'h00B4, 0, 10, "R3 8-bit lsb");
        frame(4'd11, 2'b00, 0, 1, 16'h0923, 0, 6,  "R3 12-bit code00 bipolar");
        frame(4'd2,  2'b10, 1, 1, 16'h0C35, 0, 12, "R3 12-bit code10 lsb bipolar");
        frame(4'd14, 2'b01, 0, 0, 16'h005A, 1, 0,  "R3 power-down 8-bit");
        frame(4'd15, 2'b00, 1, 0, 16'h00E1, 0, 9,  "R4 cfg2 keeps stored");
        frame(4'd15, 2'b11, 0, 1, 16'h0096, 0, 7,  "R4 cfg2 restore");
        frame(4'd15, 2'b00, 0, 0, 16'h8421, 0, 5,  "R4 cfg2 uses defaults");
        frame(4'd10, 2'b01, 0, 1, 16'h00C7, 0, 11, "R3 8-bit bipolar");
        frame(4'd0,  2'b11, 1, 0, 16'h1357, 0, 8,  "R3 16-bit lsb");
        frame(4'd13, 2'b01, 0, 0, 16'h0011, 0, 8,  "R3 closing");
        repeat (20) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule